// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the interrupt state for a set of DMA channels. Each channel sends single-cycle event pulses into the block, one pulse line per event bit. A pulse is recorded in the channel's status register only when the matching bit of that channel's record mask is set. A recorded bit then reaches the shared interrupt line only when the matching bit of the channel's signal mask is also set, and only while the global interrupt enable is on. Recording and signalling are gated separately, so software can watch an event in status without being interrupted by it. Pausing a channel is the usual example: the suspended event is recorded but not signalled.

Software uses a plain register port. It writes both masks and the global enable, reads any register, and removes status bits by writing ones to a per-channel write-one-to-clear register. Event bit positions are fixed. Bit 0 is transfer done, bit 1 is suspended, and bits 2 and up are error sources. Each position is a separate bit, so when software finds an error bit set alongside done it can give the error precedence.

Register address: the top address bit set selects the configuration register, where bit 0 is the global enable. Otherwise, address bits [CH_W+1:2] select the channel and bits [1:0] select the register: 0 record mask, 1 signal mask, 2 status (read-only), 3 clear (write-only, reads as zero).

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on bit b of channel c sets status bit b of channel c at the next clock edge only if record-mask bit b of that channel was 1 at that edge; otherwise the status bit stays 0.
- R2: A status bit whose signal-mask bit is 0 never raises `irq_o`. For example, a suspended event (bit 1) can show in status with `irq_o` staying low.
- R3: Writing the clear register (select 3) with a 1 in bit b clears status bit b of that channel. Bits written as 0 leave status unchanged.
- R4: When an event pulse and a clear of the same status bit happen in the same cycle, the event wins and the bit ends up set. Other bits in that clear write are still cleared.
- R5: A status bit keeps its value after its record-mask bit is later set to 0. Only a clear write removes it.
- R6: With the global enable (configuration register bit 0) at 0, `irq_o` is low and status bits are kept. Setting the enable back to 1 raises `irq_o` again if anything is still pending.
- R7: `irq_o` is a register. It is high one edge after some channel holds a status bit whose signal-mask bit is 1 while the global enable is 1. It is the OR over all channels.
- R8: Reset (synchronous, active high) clears both masks of every channel, every status bit, the global enable, `irq_o` and `reg_rdata`.
- R9: `reg_rdata` is registered. After each edge it holds the register selected by `reg_addr` at that edge, with the value that register had before the edge. The clear register reads as zero, and the configuration register reads the global enable in bit 0.
- R10: Transfer done (bit 0) and error bits (bits 2 and up) are independent positions. Pulsing both in one cycle sets both.
- R11: With the record mask written to all zeros, no event pulse on that channel sets any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CH*EVT_W | Event pulses; channel c occupies bits [c*EVT_W +: EVT_W] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+3 | Register address (configuration, or channel and register select) |
| reg_wdata | input | EVT_W | Register write data |
| reg_rdata | output | EVT_W | Registered read data for `reg_addr` |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
An event pulse and a write-one-to-clear of the same status bit can land on the same clock edge. The bench provokes this by pulsing an event on a channel while writing that channel's clear register. The written mask covers both the pulsed bit and a bit that was already set. Reading status back must show the pulsed bit kept and the other bit gone. A long random phase mixes events, mask writes, clears and enable changes at random, so collisions also occur by chance. Each of those cycles is compared against the behavioural model.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Register select in address bits [1:0]
  typedef enum logic [1:0] {
    SEL_REC  = 2'd0,
    SEL_SIG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CLR  = 2'd3
  } reg_sel_e;

  // Fixed event positions (software relies on these)
  localparam int EVT_DONE    = 0;
  localparam int EVT_SUSPEND = 1;
  localparam int EVT_ERR_LSB = 2;

endpackage

// File: rtl/irq_chan_slot.sv
// One channel: record mask, signal mask and sticky status.
module irq_chan_slot #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt,
  input  logic             rec_we,
  input  logic             sig_we,
  input  logic [EVT_W-1:0] wdata,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] rec_o,
  output logic [EVT_W-1:0] sig_o,
  output logic [EVT_W-1:0] stat_o,
  output logic             pend_o
);

  logic [EVT_W-1:0] rec_q, sig_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= '0;
      sig_q  <= '0;
      stat_q <= '0;
    end else begin
      if (rec_we) rec_q <= wdata;
      if (sig_we) sig_q <= wdata;
      // set term applied after clear term: a same-cycle event survives
      stat_q <= (stat_q & ~clr_mask) | (evt & rec_q);
    end
  end

  assign rec_o  = rec_q;
  assign sig_o  = sig_q;
  assign stat_o = stat_q;
  assign pend_o = |(stat_q & sig_q);

endmodule

// File: rtl/irq_reg_readback.sv
// Registered read multiplexer over all channel registers and the config bit.
module irq_reg_readback import irq_stat_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int EVT_W  = 8,
  parameter int CH_W   = 2,
  parameter int ADDR_W = CH_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NUM_CH*EVT_W-1:0] rec_flat,
  input  logic [NUM_CH*EVT_W-1:0] sig_flat,
  input  logic [NUM_CH*EVT_W-1:0] stat_flat,
  input  logic                    gie,
  output logic [EVT_W-1:0]        rdata
);

  logic [EVT_W-1:0] rd_next;
  logic [CH_W-1:0]  ch_idx;
  reg_sel_e         sel;

  assign ch_idx = addr[CH_W+1:2];
  assign sel    = reg_sel_e'(addr[1:0]);

  always_comb begin
    rd_next = '0;
    if (addr[ADDR_W-1]) begin
      rd_next[0] = gie;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_W'(c)) begin
          unique case (sel)
            SEL_REC:  rd_next = rec_flat[c*EVT_W +: EVT_W];
            SEL_SIG:  rd_next = sig_flat[c*EVT_W +: EVT_W];
            SEL_STAT: rd_next = stat_flat[c*EVT_W +: EVT_W];
            SEL_CLR:  rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit import irq_stat_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int EVT_W  = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*EVT_W-1:0] evt_i,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [EVT_W-1:0]        reg_wdata,
  output logic [EVT_W-1:0]        reg_rdata,
  output logic                    irq_o
);

  logic                    is_cfg;
  logic [CH_W-1:0]         ch_idx;
  reg_sel_e                sel;
  logic [NUM_CH*EVT_W-1:0] rec_flat, sig_flat, stat_flat, clr_flat;
  logic [NUM_CH-1:0]       pend;
  logic                    gie_q, irq_q;

  assign is_cfg = reg_addr[ADDR_W-1];
  assign ch_idx = reg_addr[CH_W+1:2];
  assign sel    = reg_sel_e'(reg_addr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = reg_we && !is_cfg && (ch_idx == CH_W'(c));
    assign clr_flat[c*EVT_W +: EVT_W] = (hit && sel == SEL_CLR) ? reg_wdata : '0;

    irq_chan_slot #(.EVT_W(EVT_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt_i[c*EVT_W +: EVT_W]),
      .rec_we   (hit && sel == SEL_REC),
      .sig_we   (hit && sel == SEL_SIG),
      .wdata    (reg_wdata),
      .clr_mask (clr_flat[c*EVT_W +: EVT_W]),
      .rec_o    (rec_flat[c*EVT_W +: EVT_W]),
      .sig_o    (sig_flat[c*EVT_W +: EVT_W]),
      .stat_o   (stat_flat[c*EVT_W +: EVT_W]),
      .pend_o   (pend[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (reg_we && is_cfg) gie_q <= reg_wdata[0];
      irq_q <= gie_q & (|pend);
    end
  end

  assign irq_o = irq_q;

  irq_reg_readback #(
    .NUM_CH (NUM_CH),
    .EVT_W  (EVT_W),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .rec_flat  (rec_flat),
    .sig_flat  (sig_flat),
    .stat_flat (stat_flat),
    .gie       (gie_q),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int NUM_CH = 4,
  parameter int EVT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH*EVT_W-1:0] evt,
  input logic [NUM_CH*EVT_W-1:0] clr,
  input logic [NUM_CH*EVT_W-1:0] rec,
  input logic [NUM_CH*EVT_W-1:0] sig,
  input logic [NUM_CH*EVT_W-1:0] stat,
  input logic                    gie,
  input logic                    irq
);

  // R1: a status bit may only rise where an enabled event arrived
  assert_rise_gated_R1: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat)) & ~$past(evt & rec)) == '0);

  // R4: every enabled event lands, whatever clear came with it
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (stat & $past(evt & rec)) == $past(evt & rec));

  // R3 / R5: a status bit may only fall under a clear write
  assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ((~stat & $past(stat)) & ~$past(clr)) == '0);

  // R2: interrupt needs a signalled pending bit
  assert_irq_needs_signal_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(stat & sig)));

  // R6: interrupt needs the global enable
  assert_irq_needs_gie_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie));

  // R7: signalled pending bit with enable raises the line one edge later
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    $past(gie && (|(stat & sig))) |-> irq);

  // R8: reset clears state
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (stat == '0 && rec == '0 && sig == '0 && !gie && !irq));

endmodule

bind irq_status_unit irq_status_unit_chk #(
  .NUM_CH (NUM_CH),
  .EVT_W  (EVT_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .evt  (evt_i),
  .clr  (clr_flat),
  .rec  (rec_flat),
  .sig  (sig_flat),
  .stat (stat_flat),
  .gie  (gie_q),
  .irq  (irq_o)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int NUM_CH = 4;
  localparam int EVT_W  = 8;
  localparam int CH_W   = 2;
  localparam int ADDR_W = CH_W + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic                    rst   = 1'b1;
  logic [NUM_CH*EVT_W-1:0] evt   = '0;
  logic                    we    = 1'b0;
  logic [ADDR_W-1:0]       addr  = '0;
  logic [EVT_W-1:0]        wdata = '0;
  logic [EVT_W-1:0]        rdata;
  logic                    irq;

  irq_status_unit #(.NUM_CH(NUM_CH), .EVT_W(EVT_W)) u_irq_status_unit (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [EVT_W-1:0] act, input logic [EVT_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [EVT_W-1:0] m_rec [NUM_CH];
  logic [EVT_W-1:0] m_sig [NUM_CH];
  logic [EVT_W-1:0] m_stat[NUM_CH];
  logic             m_gie, m_irq;
  logic [EVT_W-1:0] m_rdata;
  logic [EVT_W-1:0] t_rv, t_clr;
  logic             t_any;
  int               t_ch, t_sel;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        m_rec[c] = '0; m_sig[c] = '0; m_stat[c] = '0;
      end
      m_gie = 1'b0; m_irq = 1'b0; m_rdata = '0;
    end else begin
      t_ch  = int'(addr[CH_W+1:2]);
      t_sel = int'(addr[1:0]);
      t_rv  = '0;
      if (addr[ADDR_W-1]) t_rv[0] = m_gie;
      else if (t_sel == 0) t_rv = m_rec[t_ch];
      else if (t_sel == 1) t_rv = m_sig[t_ch];
      else if (t_sel == 2) t_rv = m_stat[t_ch];
      t_any = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
        if ((m_stat[c] & m_sig[c]) != '0) t_any = 1'b1;
      for (int c = 0; c < NUM_CH; c++) begin
        t_clr = (we && !addr[ADDR_W-1] && t_ch == c && t_sel == 3) ? wdata : '0;
        m_stat[c] = (m_stat[c] & ~t_clr) | (evt[c*EVT_W +: EVT_W] & m_rec[c]);
      end
      if (we && addr[ADDR_W-1]) m_gie = wdata[0];
      else if (we && t_sel == 0) m_rec[t_ch] = wdata;
      else if (we && t_sel == 1) m_sig[t_ch] = wdata;
      m_irq   = m_gie_prev_and(t_any);
      m_rdata = t_rv;
    end
  end

  logic m_gie_hold = 1'b0;
  // gie as it stood before this edge's write
  always @(negedge clk) m_gie_hold = m_gie;
  function automatic logic m_gie_prev_and(input logic any);
    return m_gie_hold & any;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(irq === m_irq, "R7 irq vs model", {7'b0, irq}, {7'b0, m_irq});
      chk(rdata === m_rdata, "R9 rdata vs model", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [ADDR_W-1:0] ra(input int ch, input int sel);
    logic [CH_W-1:0] c = CH_W'(ch);
    logic [1:0]      s = 2'(sel);
    return {1'b0, c, s};
  endfunction
  localparam logic [ADDR_W-1:0] CFG = {1'b1, {(ADDR_W-1){1'b0}}};

  function automatic logic [NUM_CH*EVT_W-1:0] ev(input int ch, input logic [EVT_W-1:0] v);
    logic [NUM_CH*EVT_W-1:0] f = '0;
    f[ch*EVT_W +: EVT_W] = v;
    return f;
  endfunction

  task automatic cyc(input logic [NUM_CH*EVT_W-1:0] e, input logic w,
                     input logic [ADDR_W-1:0] a, input logic [EVT_W-1:0] d);
    evt = e; we = w; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [EVT_W-1:0] d);
    cyc('0, 1'b1, a, d);
  endtask

  task automatic pulse(input logic [NUM_CH*EVT_W-1:0] e);
    cyc(e, 1'b0, '0, '0);
  endtask

  task automatic idle();
    cyc('0, 1'b0, '0, '0);
  endtask

  task automatic rd_expect(input logic [ADDR_W-1:0] a, input logic [EVT_W-1:0] exp,
                           input string tag);
    cyc('0, 1'b0, a, '0);
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // ---------------- directed and random sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R8: reset state
    chk(irq === 1'b0, "R8 irq after reset", {7'b0, irq}, 8'h00);
    rd_expect(ra(0, 0), 8'h00, "R8 record mask after reset");
    rd_expect(ra(0, 2), 8'h00, "R8 status after reset");
    rd_expect(CFG,      8'h00, "R8 config after reset");

    // R11: all-zero record mask records nothing
    wr(ra(0, 0), 8'hFF);
    wr(ra(0, 0), 8'h00);
    pulse(ev(0, 8'hFF));
    rd_expect(ra(0, 2), 8'h00, "R11 zero record mask");

    // R1: only enabled positions recorded
    wr(ra(0, 0), 8'h05);
    pulse(ev(0, 8'hFF));
    rd_expect(ra(0, 2), 8'h05, "R1 gated recording");

    // R2: suspended event recorded but not signalled
    wr(CFG, 8'h01);
    wr(ra(1, 0), 8'h02);
    wr(ra(1, 1), 8'h01);
    pulse(ev(1, 8'h02));
    rd_expect(ra(1, 2), 8'h02, "R2 suspended in status");
    idle(); idle();
    chk(irq === 1'b0, "R2 no irq without signal mask", {7'b0, irq}, 8'h00);

    // R7: latency of the registered interrupt
    wr(ra(0, 1), 8'h04);
    chk(irq === 1'b0, "R7 irq not yet", {7'b0, irq}, 8'h00);
    idle();
    chk(irq === 1'b1, "R7 irq raised", {7'b0, irq}, 8'h01);

    // R6: global enable masks without losing status
    wr(CFG, 8'h00);
    chk(irq === 1'b1, "R6 irq one edge after disable", {7'b0, irq}, 8'h01);
    idle();
    chk(irq === 1'b0, "R6 irq masked", {7'b0, irq}, 8'h00);
    rd_expect(ra(0, 2), 8'h05, "R6 status kept");
    wr(CFG, 8'h01);
    idle();
    chk(irq === 1'b1, "R6 irq back", {7'b0, irq}, 8'h01);

    // R3: write-one-to-clear
    wr(ra(0, 3), 8'h00);
    rd_expect(ra(0, 2), 8'h05, "R3 zero write no effect");
    wr(ra(0, 3), 8'h01);
    rd_expect(ra(0, 2), 8'h04, "R3 clear bit0");
    chk(irq === 1'b1, "R3 irq still pending", {7'b0, irq}, 8'h01);
    wr(ra(0, 3), 8'h04);
    rd_expect(ra(0, 2), 8'h00, "R3 clear bit2");
    chk(irq === 1'b0, "R3 irq dropped", {7'b0, irq}, 8'h00);

    // R4: event and clear on the same edge
    wr(ra(2, 0), 8'hFF);
    pulse(ev(2, 8'h08));
    cyc(ev(2, 8'h01), 1'b1, ra(2, 3), 8'h09);
    rd_expect(ra(2, 2), 8'h01, "R4 event wins over clear");

    // R5: status kept after record mask removed
    wr(ra(2, 0), 8'h00);
    pulse(ev(2, 8'hFF));
    rd_expect(ra(2, 2), 8'h01, "R5 status retained");

    // R10: done and error together
    wr(ra(3, 0), 8'hFF);
    pulse(ev(3, 8'h21));
    rd_expect(ra(3, 2), 8'h21, "R10 done and error both set");

    // R7: OR across channels (only channel 3 signalled)
    wr(ra(3, 1), 8'h20);
    idle();
    chk(irq === 1'b1, "R7 irq from channel 3", {7'b0, irq}, 8'h01);

    // R9: readback
    rd_expect(ra(3, 3), 8'h00, "R9 clear reads zero");
    rd_expect(ra(1, 1), 8'h01, "R9 signal mask readback");
    rd_expect(ra(3, 1), 8'h20, "R9 signal mask ch3");
    rd_expect(CFG,      8'h01, "R9 config readback");

    // random phase compared each clock against the model
    for (int i = 0; i < 3000; i++) begin
      logic [NUM_CH*EVT_W-1:0] e;
      e = '0;
      for (int c = 0; c < NUM_CH; c++)
        if ($urandom_range(0, 3) == 0) e[c*EVT_W +: EVT_W] = EVT_W'($urandom);
      if ($urandom_range(0, 15) == 0)
        cyc(e, 1'b1, CFG, EVT_W'($urandom_range(0, 1)));
      else
        cyc(e, ($urandom_range(0, 9) < 3), ADDR_W'($urandom_range(0, (1 << (ADDR_W-1)) - 1)),
            EVT_W'($urandom));
    end

    idle(); idle();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
      $finish;
    end
  end

endmodule